// File: doc/BRIEF.md
# Rate-Limited Serial Fan and Temperature Poller

This block reads a slow hardware-monitor chip over a three-wire link: an active-low select, a serial clock it drives, and one data line coming back. Each read lowers the select, waits a long settle time, then clocks in one 32-bit word. The word holds a framing byte, a fan-speed byte and a 16-bit temperature. A word with a correct framing byte updates both cached values in the same cycle. A word with a wrong framing byte leaves the cache as it was and raises a sticky error.

All timing is counted in system clock cycles from parameters: the settle delay, the clock phase time and the minimum gap between reads. Settle and phase values below their safe floors are raised to the floor. A request is served from the cache, with no bus activity, when it comes within the minimum gap after the last read and the cache holds a good frame. While no good frame has arrived since reset, every request from idle starts a transfer.

Top module: `hwmon_reader`

## Requirements
- R1: While reset is held, and after it, until a request arrives, cs_n_o is 1, sclk_o is 0, fan_o and temp_o are 0, and valid_o and err_o are 0.
- R2: The first rising edge of sclk_o comes exactly SETTLE_CYC clock cycles after cs_n_o falls. A SETTLE_CYC below SETTLE_MIN_CYC is replaced by SETTLE_MIN_CYC.
- R3: Each high phase and each low phase of sclk_o lasts PHASE_CYC cycles. A PHASE_CYC below PHASE_MIN_CYC is replaced by PHASE_MIN_CYC. sclk_o is low whenever cs_n_o is high.
- R4: One transfer gives exactly 32 rising edges of sclk_o. sdata_i is sampled at each rising edge, most significant bit first. cs_n_o returns high at the end of the low phase that follows the 32nd bit.
- R5: In the received word, bits 31:24 are the framing byte (0x55 when good), bits 23:16 are the fan speed in steps of 100 RPM, and bits 15:0 are the temperature in steps of 0.1 degree. On a good frame, fan_o and temp_o take the new values in the same cycle that cs_n_o rises, and valid_o is high for that one cycle.
- R6: A frame whose framing byte is not 0x55 leaves fan_o and temp_o unchanged and keeps valid_o low. It sets err_o, which stays high until the next good frame clears it.
- R7: After a transfer that stored a good frame, a request within INTERVAL_CYC cycles of its end starts no transfer and leaves the outputs unchanged. A request after that window starts a transfer.
- R8: While no good frame has been stored since reset, a request from idle starts a transfer even inside the window.
- R9: A request that arrives while a transfer is running is ignored and does not cause a second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Read request, sampled while idle |
| sdata_i | input | 1 | Serial data from the monitor chip |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles low |
| fan_o | output | 8 | Cached fan speed, 100 RPM units |
| temp_o | output | 16 | Cached temperature, 0.1 degree units |
| valid_o | output | 1 | One-cycle pulse when a good frame is stored |
| err_o | output | 1 | Sticky bad-frame flag |

## Verification
The hardest case to reach from the ports is a request that falls inside the rate-limit window while the cache is still invalid. The bench gets there by sending a bad frame first, so the window is running but no good frame is held. It then checks that a request made during that transfer is dropped, and that a later request inside the window still starts a new transfer. A second instance, whose settle and phase parameters are set below their floors, shows that the floors are applied.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;
    localparam int MARK_W = 8;
    localparam int FAN_W  = 8;
    localparam int TEMP_W = 16;
    localparam int WORD_W = MARK_W + FAN_W + TEMP_W;
    localparam logic [MARK_W-1:0] FRAME_MARK = 8'h55;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_HI,
        ST_LO
    } rd_state_e;
endpackage

// File: rtl/hwmon_frame_split.sv
module hwmon_frame_split
    import hwmon_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic              good_o,
    output logic [FAN_W-1:0]  fan_o,
    output logic [TEMP_W-1:0] temp_o
);
    always_comb begin
        good_o = (word_i[WORD_W-1 -: MARK_W] == FRAME_MARK);
        fan_o  = word_i[TEMP_W +: FAN_W];
        temp_o = word_i[0 +: TEMP_W];
    end
endmodule

// File: rtl/hwmon_rate_gate.sv
module hwmon_rate_gate #(
    parameter int INTERVAL_CYC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic hold_o
);
    localparam int IV_W = $clog2(INTERVAL_CYC + 1);

    logic [IV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = IV_W'(INTERVAL_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hold_o = (cnt_q != '0);

    // R7
    restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && (INTERVAL_CYC > 1)) |=> hold_o);
endmodule

// File: rtl/hwmon_reader.sv
module hwmon_reader
    import hwmon_pkg::*;
#(
    parameter int SETTLE_CYC     = 5_000_000,
    parameter int SETTLE_MIN_CYC = 500_000,
    parameter int PHASE_CYC      = 5_000,
    parameter int PHASE_MIN_CYC  = 750,
    parameter int INTERVAL_CYC   = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              sdata_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic [FAN_W-1:0]  fan_o,
    output logic [TEMP_W-1:0] temp_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int SETTLE_EFF = (SETTLE_CYC < SETTLE_MIN_CYC) ? SETTLE_MIN_CYC : SETTLE_CYC;
    localparam int PHASE_EFF  = (PHASE_CYC < PHASE_MIN_CYC) ? PHASE_MIN_CYC : PHASE_CYC;
    localparam int CNT_MAX    = (SETTLE_EFF > PHASE_EFF) ? SETTLE_EFF : PHASE_EFF;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam int BIT_W      = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    typedef struct packed {
        rd_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [BIT_W-1:0]   bidx;
        logic [WORD_W-1:0]  shreg;
        logic               csn;
        logic               sclk;
        logic [FAN_W-1:0]   fan;
        logic [TEMP_W-1:0]  temp;
        logic               have;
        logic               err;
        logic               valid;
    } rd_regs_t;

    rd_regs_t r_d, r_q;
    logic fin;
    logic hold;
    logic good;
    logic [FAN_W-1:0]  new_fan;
    logic [TEMP_W-1:0] new_temp;

    hwmon_frame_split u_split (
        .word_i (r_q.shreg),
        .good_o (good),
        .fan_o  (new_fan),
        .temp_o (new_temp)
    );

    hwmon_rate_gate #(.INTERVAL_CYC(INTERVAL_CYC)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (fin),
        .hold_o    (hold)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        fin       = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_i && (!r_q.have || !hold)) begin
                    r_d.st   = ST_SETTLE;
                    r_d.csn  = 1'b0;
                    r_d.cnt  = CNT_W'(SETTLE_EFF - 1);
                    r_d.bidx = '0;
                end
            end
            ST_SETTLE: begin
                if (r_q.cnt == '0) begin
                    r_d.st    = ST_HI;
                    r_d.sclk  = 1'b1;
                    r_d.cnt   = CNT_W'(PHASE_EFF - 1);
                    r_d.shreg = {r_q.shreg[WORD_W-2:0], sdata_i};
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_HI: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_LO;
                    r_d.sclk = 1'b0;
                    r_d.cnt  = CNT_W'(PHASE_EFF - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_LO: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.bidx == LAST_BIT) begin
                    fin     = 1'b1;
                    r_d.st  = ST_IDLE;
                    r_d.csn = 1'b1;
                    if (good) begin
                        r_d.fan   = new_fan;
                        r_d.temp  = new_temp;
                        r_d.have  = 1'b1;
                        r_d.err   = 1'b0;
                        r_d.valid = 1'b1;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end else begin
                    r_d.bidx  = r_q.bidx + 1'b1;
                    r_d.st    = ST_HI;
                    r_d.sclk  = 1'b1;
                    r_d.cnt   = CNT_W'(PHASE_EFF - 1);
                    r_d.shreg = {r_q.shreg[WORD_W-2:0], sdata_i};
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.csn   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o  = r_q.csn;
    assign sclk_o  = r_q.sclk;
    assign fan_o   = r_q.fan;
    assign temp_o  = r_q.temp;
    assign valid_o = r_q.valid;
    assign err_o   = r_q.err;

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.csn |-> !r_q.sclk);

    // R7 R8
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.csn) |-> $past(!r_q.have || !hold));

    // R5
    cache_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(r_q.fan) || !$stable(r_q.temp)) |-> r_q.valid);

    // R6
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |-> !r_q.err);

    // R4
    valid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |-> ($rose(r_q.csn) && $past(r_q.st == ST_LO)));
endmodule

// File: tb/sim_hwmon_reader.sv
module sim_hwmon_reader;
    localparam int S    = 20;
    localparam int SMIN = 10;
    localparam int P    = 4;
    localparam int PMIN = 3;
    localparam int IV   = 1500;

    logic clk, rst_n, req, sd;
    logic cs_n, sclk, valid, err;
    logic [7:0]  fan;
    logic [15:0] temp;
    logic u1_cs_n, u1_sclk, u1_valid, u1_err;
    logic [7:0]  u1_fan;
    logic [15:0] u1_temp;

    hwmon_reader #(.SETTLE_CYC(S), .SETTLE_MIN_CYC(SMIN), .PHASE_CYC(P),
                   .PHASE_MIN_CYC(PMIN), .INTERVAL_CYC(IV)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .sdata_i(sd),
        .cs_n_o(cs_n), .sclk_o(sclk), .fan_o(fan), .temp_o(temp),
        .valid_o(valid), .err_o(err));

    hwmon_reader #(.SETTLE_CYC(4), .SETTLE_MIN_CYC(12), .PHASE_CYC(2),
                   .PHASE_MIN_CYC(5), .INTERVAL_CYC(IV)) u1 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .sdata_i(1'b0),
        .cs_n_o(u1_cs_n), .sclk_o(u1_sclk), .fan_o(u1_fan), .temp_o(u1_temp),
        .valid_o(u1_valid), .err_o(u1_err));

    localparam logic [31:0] VEC [6] = '{
        32'h552A01F4, 32'h55FFFFFF, 32'hAA112222,
        32'h55000000, 32'h54334444, 32'h55808001
    };

    int errors = 0;
    int checks = 0;
    logic [31:0] tx;
    int bi;

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // monitor chip model: presents MSB on select fall, next bit on each clock fall
    always @(negedge cs_n) begin
        bi = 31;
        sd = tx[31];
    end
    always @(negedge sclk) begin
        if (!cs_n && bi > 0) begin
            bi = bi - 1;
            sd = tx[bi];
        end
    end

    int cyc = 0, t_csf = 0, t_rise1 = 0, t_tog = 0, hi_w = 0, lo_w = 0;
    int rises = 0, n_csf = 0, n_valid = 0;
    bit first_seen = 0;
    logic cs_prev = 1'b1, sclk_prev = 1'b0;
    int u1_csf = 0, u1_rise1 = 0, u1_tog = 0, u1_hi = 0;
    bit u1_first = 0;
    logic u1_cs_prev = 1'b1, u1_sclk_prev = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cs_prev && !cs_n) begin
            t_csf = cyc; n_csf = n_csf + 1; rises = 0; first_seen = 0;
        end
        if (!sclk_prev && sclk) begin
            rises = rises + 1;
            if (!first_seen) begin t_rise1 = cyc; first_seen = 1; end
            else lo_w = cyc - t_tog;
            t_tog = cyc;
        end
        if (sclk_prev && !sclk) begin hi_w = cyc - t_tog; t_tog = cyc; end
        if (valid) n_valid = n_valid + 1;
        cs_prev = cs_n; sclk_prev = sclk;
        if (u1_cs_prev && !u1_cs_n) begin u1_csf = cyc; u1_first = 0; end
        if (!u1_sclk_prev && u1_sclk) begin
            if (!u1_first) begin u1_rise1 = cyc; u1_first = 1; end
            u1_tog = cyc;
        end
        if (u1_sclk_prev && !u1_sclk) u1_hi = cyc - u1_tog;
        u1_cs_prev = u1_cs_n; u1_sclk_prev = u1_sclk;
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic pulse_req();
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        bit ok = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (cs_n) begin ok = 1; break; end
        end
        chk(tag, "transfer ended", longint'(ok), 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        report();
        $finish;
    end

    initial begin
        logic [7:0]  mfan;
        logic [15:0] mtemp;
        logic        merr;
        int          nv, nc;
        rst_n = 1'b0; req = 1'b0; tx = 32'h0; sd = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1", "cs_n", cs_n, 1);
        chk("R1", "sclk", sclk, 0);
        chk("R1", "fan", fan, 0);
        chk("R1", "temp", temp, 0);
        chk("R1", "valid/err", {valid, err}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "idle cs_n after reset", cs_n, 1);

        // bad first frame, with a request during the transfer
        tx = 32'hAA123456;
        pulse_req();
        repeat (60) @(negedge clk);
        pulse_req();
        wait_done("R6");
        chk("R2", "settle cycles", t_rise1 - t_csf, S);
        chk("R3", "high phase", hi_w, P);
        chk("R3", "low phase", lo_w, P);
        chk("R4", "rising edges", rises, 32);
        chk("R6", "err set", err, 1);
        chk("R6", "fan unchanged", fan, 0);
        chk("R6", "temp unchanged", temp, 0);
        chk("R6", "no valid", n_valid, 0);
        nc = n_csf;
        repeat (400) @(negedge clk);
        chk("R9", "no extra transfer", n_csf, nc);

        // cache invalid: request inside the window still starts a transfer
        tx = VEC[0];
        pulse_req();
        repeat (2) @(negedge clk);
        chk("R8", "cs_n low in window", cs_n, 0);
        wait_done("R8");
        chk("R5", "fan", fan, 8'h2A);
        chk("R5", "temp", temp, 16'h01F4);
        chk("R6", "err cleared", err, 0);
        chk("R5", "valid pulses", n_valid, 1);
        mfan = 8'h2A; mtemp = 16'h01F4; merr = 1'b0;

        // rate limit: served from cache
        tx = 32'h55777777;
        nc = n_csf;
        pulse_req();
        repeat (500) @(negedge clk);
        chk("R7", "no transfer in window", n_csf, nc);
        chk("R7", "fan kept", fan, mfan);
        chk("R7", "temp kept", temp, mtemp);

        // vector table walk, each after the window
        foreach (VEC[k]) begin
            tx = VEC[k];
            repeat (IV + 20) @(negedge clk);
            nv = n_valid; nc = n_csf;
            pulse_req();
            wait_done("R7");
            chk("R7", "transfer after window", n_csf, nc + 1);
            chk("R4", "rising edges", rises, 32);
            if (VEC[k][31:24] == 8'h55) begin
                mfan = VEC[k][23:16]; mtemp = VEC[k][15:0]; merr = 1'b0;
                chk("R5", "valid pulse", n_valid, nv + 1);
            end else begin
                merr = 1'b1;
                chk("R6", "no valid on bad frame", n_valid, nv);
            end
            chk("R5", "fan", fan, mfan);
            chk("R5", "temp", temp, mtemp);
            chk("R6", "err", err, merr);
        end

        // floors on the second instance
        chk("R2", "settle floor", u1_rise1 - u1_csf, 12);
        chk("R3", "phase floor", u1_hi, 5);

        report();
        $finish;
    end
endmodule